// File: doc/BRIEF.md
# Byte-Matrix Substitute-and-Mix Unit

This unit takes a 128-bit word as a 4x4 matrix of bytes. Each of the sixteen bytes goes through its own 8-bit substitution box. The sixteen substituted bytes are then treated as one vector and multiplied by a fixed 16x16 matrix over GF(2^8). The matrix couples every byte in a column with different weights, and it adds in the bytes that share its row in the other three columns. The result is a 128-bit word in the same byte layout. The unit is meant to sit in the round datapath of a wide permutation. The logic around it sequences the state and supplies one word per clock.

A parameter picks one of two forms. In the default form, a register bank sits between the substitution half and the mix half. That bank loads on the falling clock edge and is enabled by the input strobe, so the result of a word presented after a rising edge is ready before the next rising edge. The substitution glitches also stop at the bank. In the other form the unit is purely combinational, and its output strobe is a copy of its input strobe. The constant multipliers (by 4, 5, 6 and 7) are built from doubling steps and XORs only.

Top module: `byte_supermix`

## Requirements
- R1: Byte k of a word sits at bits [8k+7:8k], and k = 4c + r addresses row r (0..3) of column c (0..3). The same layout applies to the input and to the output.
- R2: Each input byte x is replaced by s(x). This is the multiplicative inverse of x in GF(2^8) (with 0 mapped to 0), followed by the affine map b XOR rotl(b,1) XOR rotl(b,2) XOR rotl(b,3) XOR rotl(b,4) XOR 0x63. For example s(0x00) = 0x63 and s(0x53) = 0xED.
- R3: Output byte (c,r) = 4*s(c,r) ^ 5*s(c,r+1) ^ 6*s(c,r+2) ^ 7*s(c,r+3), with row indices mod 4, XORed with s(c',r) for each of the three columns c' other than c.
- R4: All products are taken in GF(2^8) modulo x^8 + x^4 + x^3 + x + 1 (0x11B).
- R5: An input with all sixteen bytes equal to b yields sixteen output bytes equal to s(b), because each output's coefficients XOR to 1. An all-zero input therefore yields all 0x63.
- R6: In the default registered form, when in_valid is high after a rising edge, out_valid is high and out_data carries that word's result before the next rising edge.
- R7: In the registered form, while in_valid is low the stage does not load. out_valid is low and out_data keeps the last result, whatever in_data does.
- R8: While rst_n is low, out_valid is 0 and out_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the inner stage loads on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word strobe; also the load enable of the inner stage |
| in_data | input | 128 | Input byte matrix, column-major |
| out_valid | output | 1 | Result strobe |
| out_data | output | 128 | Mixed byte matrix, column-major |

## Verification
A wrong substitution entry or a wrong mix coefficient corrupts every valid output that uses the affected byte or term, in the same clock cycle the word is presented. Single-byte impulses isolate each column of the mix matrix, and they expose a swapped row or column index straight away. A bad load enable on the falling-edge stage only becomes visible in the following idle cycle, where out_data must not move while in_data keeps changing.

// File: rtl/byte_supermix.sv
module byte_supermix #(
  parameter bit NEG_STAGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] in_data,
  output logic         out_valid,
  output logic [127:0] out_data
);

  function automatic logic [7:0] dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = dbl(sh);
    end
    return acc;
  endfunction

  function automatic logic [7:0] subst(input logic [7:0] x);
    logic [7:0] sq, inv, b;
    inv = 8'h01;
    sq  = x;
    for (int i = 1; i < 8; i++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    b = inv;
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  logic [127:0] sub_w;
  logic [127:0] mid;

  for (genvar k = 0; k < 16; k++) begin : g_sbox
    assign sub_w[8*k +: 8] = subst(in_data[8*k +: 8]);
  end

  if (NEG_STAGE) begin : g_neg
    logic [127:0] mid_q;
    logic         vld_q;
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mid_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) mid_q <= sub_w;
      end
    end
    assign mid       = mid_q;
    assign out_valid = vld_q;

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> $stable(out_data));
  end else begin : g_comb
    assign mid       = sub_w;
    assign out_valid = in_valid;
  end

  always_comb begin
    out_data = '0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        logic [7:0] s0, s1, s2, s3, m2, acc;
        s0  = mid[8*(4*c + r) +: 8];
        s1  = mid[8*(4*c + ((r + 1) % 4)) +: 8];
        s2  = mid[8*(4*c + ((r + 2) % 4)) +: 8];
        s3  = mid[8*(4*c + ((r + 3) % 4)) +: 8];
        acc = dbl(dbl(s0));
        acc = acc ^ dbl(dbl(s1)) ^ s1;
        m2  = dbl(s2);
        acc = acc ^ dbl(m2) ^ m2;
        m2  = dbl(s3);
        acc = acc ^ dbl(m2) ^ m2 ^ s3;
        for (int cc = 0; cc < 4; cc++)
          if (cc != c) acc = acc ^ mid[8*(4*cc + r) +: 8];
        out_data[8*(4*c + r) +: 8] = acc;
      end
    end
  end

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == in_valid);

  // R5
  zero_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '0) |-> out_data == {16{8'h63}});

  // R5
  uniform_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == {16{in_data[7:0]}}) |-> out_data == {16{out_data[7:0]}});

  // R8
  always_comb begin
    if (!rst_n && NEG_STAGE) begin
      reset_state_chk: assert (out_valid == 1'b0 && out_data == '0);
    end
  end

endmodule

// File: tb/sim_byte_supermix.sv
module sim_byte_supermix;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int sb_t [256];
  logic [127:0] exp_data = '0;

  always #10 clk = ~clk;

  byte_supermix u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic int gm(int a, int b);
    int p = 0;
    for (int i = 0; i < 8; i++) if ((b >> i) & 1) p = p ^ (a << i);
    for (int i = 14; i >= 8; i--) if ((p >> i) & 1) p = p ^ (32'h11B << (i - 8));
    return p;
  endfunction

  function automatic int sb_calc(int x);
    int inv = 0, r = 0;
    if (x != 0) for (int y = 1; y < 256; y++) if (gm(x, y) == 1) inv = y;
    for (int i = 0; i < 8; i++) begin
      int bit_v;
      bit_v = ((inv >> i) & 1) ^ ((inv >> ((i + 4) % 8)) & 1) ^ ((inv >> ((i + 5) % 8)) & 1)
            ^ ((inv >> ((i + 6) % 8)) & 1) ^ ((inv >> ((i + 7) % 8)) & 1) ^ ((8'h63 >> i) & 1);
      r = r | (bit_v << i);
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_out(logic [127:0] d);
    logic [127:0] o = '0;
    int s [16];
    for (int k = 0; k < 16; k++) s[k] = sb_t[d[8*k +: 8]];
    for (int i = 0; i < 16; i++) begin
      int acc = 0;
      for (int k = 0; k < 16; k++) begin
        int coef;
        if (i / 4 == k / 4) coef = 4 + ((k % 4 - i % 4 + 4) % 4);
        else if (i % 4 == k % 4) coef = 1;
        else coef = 0;
        acc = acc ^ gm(coef, s[k]);
      end
      o[8*i +: 8] = acc[7:0];
    end
    return o;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(bit v, logic [127:0] d, string req);
    @(posedge clk);
    #1;
    in_valid = v;
    in_data  = d;
    if (v) exp_data = ref_out(d);
    #16;
    check(out_valid == v, {req, " out_valid (R6)"}, {127'd0, out_valid}, {127'd0, v});
    check(out_data == exp_data, req, out_data, exp_data);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int x = 0; x < 256; x++) sb_t[x] = sb_calc(x);
    check(sb_t[0] == 8'h63, "R2 s(00)", 128'(sb_t[0]), 128'h63);
    check(sb_t[8'h53] == 8'hED, "R2 s(53)", 128'(sb_t[8'h53]), 128'hED);
    repeat (3) @(posedge clk);
    #17;
    // R8 reset state
    check(out_valid == 1'b0, "R8 out_valid", {127'd0, out_valid}, '0);
    check(out_data == '0, "R8 out_data", out_data, '0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // R5 zero and uniform inputs
    step(1'b1, '0, "R5 zero");
    check(out_data == {16{8'h63}}, "R5 zero literal", out_data, {16{8'h63}});
    step(1'b1, {16{8'h53}}, "R5 uniform");
    check(out_data == {16{8'hED}}, "R2 R5 uniform literal", out_data, {16{8'hED}});

    // R7 idle holds last result while data moves
    step(1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R7 idle");
    step(1'b0, {16{8'hA5}}, "R7 idle");

    // R1 R3 single-byte impulses on a zero background
    for (int k = 0; k < 16; k++) begin
      logic [127:0] d = '0;
      d[8*k +: 8] = 8'h01;
      step(1'b1, d, "R1 R3 impulse");
    end

    // R4 bytes with high bit set exercise the reduction
    step(1'b1, {16{8'h80}} ^ 128'h00FF_00FF_8000_0080_FF00_7F00_8181_C3C3, "R4 reduce");

    // R3 R4 R6 random words, back to back, with idle gaps
    for (int n = 0; n < 40; n++) begin
      logic [127:0] d = {$urandom, $urandom, $urandom, $urandom};
      step((n % 7) != 3, d, "R3 R6 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule